// File: doc/BRIEF.md
# 10BASE-T Transmit Supervisor: Heartbeat and Jabber Guard

This block sits beside the 10 Mb/s transmit path of a twisted-pair transceiver. It watches the enable that the MAC drives and the collision condition found by the line receiver. It produces three things: the collision value that goes back to the MAC, a gated transmit enable for the line driver, and a jabber status flag. The collision value carries a one-microsecond heartbeat. The heartbeat starts one microsecond after each transmission ends. It is withheld when a collision was seen during that transmission, when the port is a repeater port, and when heartbeat generation is switched off. The jabber guard cuts off a transmission that runs longer than a limit. It holds the driver off until the enable has stayed low for the full release interval.

All timing is counted in ticks of a timebase strobe. `TICKS_PER_US` ticks make one microsecond, so a 10 MHz strobe gives 10. The jabber limit is `JABBER_US`, default 20 ms. Values from 20 to 150 ms are intended. The release interval is `UNJAB_US`, default 500 ms. The heartbeat machine has four states:
- SQ_IDLE
- SQ_XMIT: a frame is in progress.
- SQ_WAIT: the one-microsecond delay.
- SQ_BEAT: the one-microsecond pulse.

Its transitions are:
- SQ_IDLE to SQ_XMIT when the enable rises.
- SQ_XMIT to SQ_WAIT when the enable falls and nothing suppresses the heartbeat.
- SQ_XMIT to SQ_IDLE when the enable falls and the heartbeat is suppressed.
- SQ_WAIT to SQ_BEAT when the delay expires.
- SQ_BEAT to SQ_IDLE when the pulse expires.
- SQ_WAIT or SQ_BEAT back to SQ_XMIT when the enable rises again.

The jabber machine also has four states:
- JB_IDLE
- JB_RUN: counts the frame length.
- JB_LOCK: cut off while the enable is still high.
- JB_COOL: cut off while the idle interval is counted.

Its transitions are:
- JB_IDLE to JB_RUN when the enable rises.
- JB_RUN to JB_IDLE when the enable falls.
- JB_RUN to JB_LOCK when the limit is reached.
- JB_LOCK to JB_COOL when the enable falls.
- JB_COOL to JB_LOCK when the enable rises again.
- JB_COOL to JB_IDLE when the release interval expires.

Top module: `tenbt_tx_supervisor`

## Requirements
- R1: In the cycle where a transmission's enable is first sampled low, a delay of `TICKS_PER_US` ticks begins. At its end the collision output goes high for exactly `TICKS_PER_US` ticks. With a tick in every cycle, the output is high from the (TPU+1)-th through the (2·TPU)-th falling clock edge after the enable is dropped. The first of those falling edges is counted as 0.
- R2: A transmission with the collision input high in any cycle while the enable was high produces no heartbeat.
- R3: While the repeater-mode input is high at the end of a transmission, no heartbeat is produced.
- R4: While the heartbeat-disable input is high at the end of a transmission, no heartbeat is produced.
- R5: The collision output is high in every cycle in which the collision input is high.
- R6: If the enable rises again while the heartbeat is pending or running, that heartbeat is abandoned and the output stays low.
- R7: A transmission whose enable stays high for `JABBER_US·TICKS_PER_US` ticks has the gated enable forced low on the next cycle, and jabber status goes high. With a tick every cycle, the gated enable is high on exactly L+1 falling edges, where L is that tick count.
- R8: A transmission sampled high for at most L ticks never raises jabber status, and the gated enable follows the enable throughout.
- R9: After a jabber, status returns low once the enable has been sampled low for `UNJAB_US·TICKS_PER_US` consecutive ticks, U. Status is high on exactly U+1 falling edges after the enable is dropped.
- R10: Raising the enable during the release interval keeps the gated enable low and status high. It restarts the release count from zero.
- R11: Counters advance only on cycles where the tick input is high. With a tick every other cycle, the heartbeat lasts 2·TPU clock cycles.
- R12: Out of reset, the collision output, the gated enable and jabber status are low while all inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous-style reset (asynchronous assert) |
| tick | input | 1 | Timebase strobe, one per tick |
| tx_en | input | 1 | Transmit enable from the MAC |
| col_raw | input | 1 | Collision condition from the line receiver |
| rptr_mode | input | 1 | Repeater port: suppress heartbeat |
| sqe_off | input | 1 | Heartbeat generation disabled |
| col_out | output | 1 | Collision value presented to the MAC |
| tx_gate | output | 1 | Transmit enable passed to the line driver |
| jabber | output | 1 | Jabber lockout in force |

## Verification
The bench walks all eight combinations of collision, repeater and disable, and requires exactly one case to pulse. A design that latched the collision too late, or ignored either suppressor, would emit a stray heartbeat. It measures the heartbeat start and width to the cycle. An off-by-one in the delay counter, or a counter that ignored the tick gate, shows up as a shifted or stretched pulse. It sweeps frame lengths across the jabber limit. A comparison off by one trips one frame early or late. It re-raises the enable both during the heartbeat delay and during the release interval. A design that kept the old heartbeat, or did not restart the release count, would pulse or unlock too early.

// File: rtl/jsq_pkg.sv
package jsq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_XMIT,
        SQ_WAIT,
        SQ_BEAT
    } sqe_state_t;

    typedef enum logic [1:0] {
        JB_IDLE,
        JB_RUN,
        JB_LOCK,
        JB_COOL
    } jab_state_t;
endpackage

// File: rtl/jsq_tick_window.sv
module jsq_tick_window #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [WIDTH-1:0] limit,
    output logic             hit
);
    logic [WIDTH-1:0] cnt;

    assign hit = tick && (cnt == limit - WIDTH'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= hit ? '0 : cnt + WIDTH'(1);
    end

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);
endmodule

// File: rtl/jsq_sqe_fsm.sv
module jsq_sqe_fsm
    import jsq_pkg::*;
#(
    parameter int TICKS_PER_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  logic col_raw,
    input  logic rptr_mode,
    input  logic sqe_off,
    output logic beat
);
    localparam int CW = $clog2(TICKS_PER_US + 1);

    sqe_state_t state, nxt;
    logic       coll_seen;
    logic       hit;
    logic       clr;
    logic       suppress;

    assign suppress = coll_seen || col_raw || rptr_mode || sqe_off;

    jsq_tick_window #(.WIDTH(CW)) win_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (clr),
        .limit(CW'(TICKS_PER_US)),
        .hit  (hit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: if (tx_en) nxt = SQ_XMIT;
            SQ_XMIT: if (!tx_en) nxt = suppress ? SQ_IDLE : SQ_WAIT;
            SQ_WAIT: if (tx_en) nxt = SQ_XMIT; else if (hit) nxt = SQ_BEAT;
            SQ_BEAT: if (tx_en) nxt = SQ_XMIT; else if (hit) nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            coll_seen <= 1'b0;
        end else begin
            state <= nxt;
            if (state != SQ_XMIT)
                coll_seen <= tx_en && col_raw;
            else
                coll_seen <= coll_seen || col_raw;
        end
    end

    always_comb begin
        clr  = (nxt != state);
        beat = (state == SQ_BEAT);
    end

    // R1
    beat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat) |-> $past(state) == SQ_WAIT);
    // R2
    coll_supp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_XMIT && !tx_en && coll_seen) |=> state == SQ_IDLE);
    // R6
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_WAIT || state == SQ_BEAT) && tx_en) |=> state == SQ_XMIT);
endmodule

// File: rtl/jsq_jabber_fsm.sv
module jsq_jabber_fsm
    import jsq_pkg::*;
#(
    parameter int TICKS_PER_US = 10,
    parameter int JABBER_US    = 20000,
    parameter int UNJAB_US     = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    output logic tx_gate,
    output logic jabber
);
    localparam int JAB_TICKS = JABBER_US * TICKS_PER_US;
    localparam int UNJ_TICKS = UNJAB_US * TICKS_PER_US;
    localparam int MAX_TICKS = (JAB_TICKS > UNJ_TICKS) ? JAB_TICKS : UNJ_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    jab_state_t    state, nxt;
    logic          hit;
    logic          clr;
    logic [CW-1:0] lim;

    assign lim = (state == JB_COOL) ? CW'(UNJ_TICKS) : CW'(JAB_TICKS);

    jsq_tick_window #(.WIDTH(CW)) win_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (clr),
        .limit(lim),
        .hit  (hit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            JB_IDLE: if (tx_en) nxt = JB_RUN;
            JB_RUN:  if (!tx_en) nxt = JB_IDLE; else if (hit) nxt = JB_LOCK;
            JB_LOCK: if (!tx_en) nxt = JB_COOL;
            JB_COOL: if (tx_en) nxt = JB_LOCK; else if (hit) nxt = JB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= JB_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        clr     = (nxt != state);
        jabber  = (state == JB_LOCK) || (state == JB_COOL);
        tx_gate = tx_en && !jabber;
    end

    // R10
    cool_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JB_COOL && tx_en) |=> state == JB_LOCK);
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber) |-> $past(!tx_en));
endmodule

// File: rtl/tenbt_tx_supervisor.sv
module tenbt_tx_supervisor #(
    parameter int TICKS_PER_US = 10,
    parameter int JABBER_US    = 20000,
    parameter int UNJAB_US     = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  logic col_raw,
    input  logic rptr_mode,
    input  logic sqe_off,
    output logic col_out,
    output logic tx_gate,
    output logic jabber
);
    logic beat;

    jsq_sqe_fsm #(.TICKS_PER_US(TICKS_PER_US)) sqe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tx_en    (tx_en),
        .col_raw  (col_raw),
        .rptr_mode(rptr_mode),
        .sqe_off  (sqe_off),
        .beat     (beat)
    );

    jsq_jabber_fsm #(
        .TICKS_PER_US(TICKS_PER_US),
        .JABBER_US   (JABBER_US),
        .UNJAB_US    (UNJAB_US)
    ) jab_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .tx_en  (tx_en),
        .tx_gate(tx_gate),
        .jabber (jabber)
    );

    assign col_out = col_raw || beat;

    // R5
    col_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_raw |-> col_out);
    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> !tx_gate);
endmodule

// File: tb/tenbt_tx_supervisor_tb_top.sv
module tenbt_tx_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPU = 2;
    localparam int JUS = 6;
    localparam int UUS = 9;
    localparam int L   = JUS * TPU;
    localparam int U   = UUS * TPU;

    logic clk = 0, rst_n = 0, slow = 0, tick_ph = 0;
    logic tx_en = 0, col_raw = 0, rptr_mode = 0, sqe_off = 0;
    logic tick, col_out, tx_gate, jabber;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tick_ph <= ~tick_ph;
    assign tick = slow ? tick_ph : 1'b1;

    tenbt_tx_supervisor #(.TICKS_PER_US(TPU), .JABBER_US(JUS), .UNJAB_US(UUS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .col_raw(col_raw),
        .rptr_mode(rptr_mode), .sqe_off(sqe_off), .col_out(col_out),
        .tx_gate(tx_gate), .jabber(jabber)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sqe_frame(input int nhi, input bit c, input bit r, input bit d,
                             output int first, output int width);
        @(posedge clk); #1;
        rptr_mode = r; sqe_off = d; tx_en = 1; col_raw = c;
        repeat (nhi) @(posedge clk);
        #1; tx_en = 0; col_raw = 0;
        first = -1; width = 0;
        for (int k = 0; k < 3*TPU+3; k++) begin
            @(negedge clk);
            if (col_out) begin
                width++;
                if (first < 0) first = k;
            end
        end
        rptr_mode = 0; sqe_off = 0;
    endtask

    task automatic jab_frame(input int n, output int gate_hi);
        gate_hi = 0;
        @(posedge clk); #1; tx_en = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_gate) gate_hi++;
            @(posedge clk);
        end
        #1; tx_en = 0;
    endtask

    task automatic count_jab(output int hi);
        hi = 0;
        for (int k = 0; k < U+5; k++) begin
            @(negedge clk);
            if (jabber) hi++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int f, w, g, h;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 col_out", col_out, 0);
        chk("R12 tx_gate", tx_gate, 0);
        chk("R12 jabber", jabber, 0);
        @(posedge clk); #1; rst_n = 1;
        repeat (2) @(posedge clk);

        // R1..R4 sweep: collision/repeater/disable combos
        for (int c = 0; c < 8; c++) begin
            sqe_frame(3, c[0], c[1], c[2], f, w);
            if (c == 0) begin
                chk("R1 beat start", f, TPU+1);
                chk("R1 beat width", w, TPU);
            end else if (c[0]) chk("R2 collision suppresses", w, 0);
            else if (c[1])     chk("R3 repeater suppresses", w, 0);
            else               chk("R4 disable suppresses", w, 0);
        end

        // R5 collision passthrough
        @(posedge clk); #1; col_raw = 1;
        @(negedge clk); chk("R5 idle follow", col_out, 1);
        @(posedge clk); #1; tx_en = 1;
        @(negedge clk); chk("R5 tx follow", col_out, 1);
        @(posedge clk); #1; col_raw = 0; tx_en = 0;
        @(negedge clk); chk("R5 release", col_out, 0);
        repeat (3*TPU+3) @(posedge clk);

        // R6 re-raise during pending heartbeat
        @(posedge clk); #1; tx_en = 1;
        repeat (3) @(posedge clk);
        #1; tx_en = 0;
        @(posedge clk); #1; tx_en = 1;
        w = 0;
        for (int k = 0; k < 2*TPU+3; k++) begin
            @(negedge clk);
            if (col_out) w++;
        end
        chk("R6 cancelled beat", w, 0);
        @(posedge clk); #1; tx_en = 0;
        w = 0;
        for (int k = 0; k < 3*TPU+3; k++) begin
            @(negedge clk);
            if (col_out) w++;
        end
        chk("R6 later frame beats", w, TPU);

        // R7/R8 sweep across the jabber limit
        for (int n = L-1; n <= L+2; n++) begin
            jab_frame(n, g);
            chk((n >= L+1) ? "R7 gate count" : "R8 gate count", g, (n < L+1) ? n : L+1);
            @(negedge clk);
            chk((n >= L+1) ? "R7 jabber set" : "R8 no jabber", jabber, (n >= L+1) ? 1 : 0);
            if (n >= L+1) begin
                count_jab(h);
                chk("R9 release time", h, U);
                chk("R9 released", jabber, 0);
            end else begin
                repeat (3*TPU+3) @(posedge clk);
            end
        end

        // R10 re-raise during release interval
        jab_frame(L+2, g);
        repeat (5) @(posedge clk);
        #1; tx_en = 1;
        @(negedge clk);
        chk("R10 gate held low", tx_gate, 0);
        chk("R10 jabber held", jabber, 1);
        @(posedge clk); #1; tx_en = 0;
        count_jab(h);
        chk("R10 full release count", h, U+1);
        repeat (3*TPU+3) @(posedge clk);

        // R11 tick every other cycle
        slow = 1;
        sqe_frame(4, 0, 0, 0, f, w);
        chk("R11 slow beat width", w, 2*TPU);
        slow = 0;

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule